// File: doc/BRIEF.md
# Sliced Arithmetic-Logic Unit with Operand Inversion

This block is a purely combinational 32-bit arithmetic-logic unit assembled from identical one-bit cells. Every cell receives the same 3-bit operation code. The code is made of two parts: an invert flag in bit 2 and a 2-bit function select in bits 1:0. When the invert flag is set, each cell complements its `b` bit before the function stage. The same hardware therefore yields AND, OR, sum and XOR, plus their inverted-operand forms: a AND NOT b, a OR NOT b, difference and XNOR.

The carry into the least significant cell equals the invert flag. This makes the inverted sum the two's-complement difference a + ~b + 1. Carries ripple from cell to cell. The carry leaving the top cell is reported for the two arithmetic codes and is forced low otherwise. A zero flag reports an all-zero result for every code. The unit has no internal state, so there are no states or transitions. The operation code alone selects the datapath.

Top module: `alu_sliced`

## Requirements
- R1: Code 3'b000 gives `result_o = a_in & b_in`. Code 3'b001 gives `result_o = a_in | b_in`.
- R2: Code 3'b010 gives `result_o = (a_in + b_in) mod 2^32`. `carry_o` is bit 32 of the unsigned sum.
- R3: Code 3'b011 gives `result_o = a_in ^ b_in`.
- R4: Code 3'b100 gives `result_o = a_in & ~b_in`. Code 3'b101 gives `result_o = a_in | ~b_in`.
- R5: Code 3'b111 gives `result_o = ~(a_in ^ b_in)`.
- R6: Code 3'b110 gives `result_o = (a_in - b_in) mod 2^32`, formed as a + ~b + 1. `carry_o` is 1 exactly when a_in >= b_in, taken as unsigned numbers.
- R7: For every code whose bits 1:0 are not 2'b10, `carry_o` is 0.
- R8: For every code, `zero_o` is 1 exactly when all 32 bits of `result_o` are 0.
- R9: All outputs are combinational functions of the present inputs, with no register and no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand, optionally complemented |
| op_in | input | 3 | Bit 2 is the invert flag; bits 1:0 select AND, OR, sum or XOR |
| result_o | output | 32 | Function result |
| carry_o | output | 1 | Carry out of bit 31 for the arithmetic codes, otherwise 0 |
| zero_o | output | 1 | High when `result_o` is all zeros |

## Verification
Every result of this unit is due in the same cycle as its stimulus, because no register lies between the ports. The bench applies each operand pair and code on a falling clock edge. It compares result, carry and zero flag against its behavioural model one time unit after the following rising edge, well away from the edge on which the next stimulus is applied. Corner operands are exercised under all eight codes: zero, all ones, the sign bit alone, equal operands and values one apart. Random operands follow.

// File: rtl/alu_pkg.sv
package alu_pkg;
    parameter int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        FN_AND = 2'b00,
        FN_OR  = 2'b01,
        FN_SUM = 2'b10,
        FN_XOR = 2'b11
    } alu_fn_e;

    typedef struct packed {
        logic    inv_b;
        alu_fn_e fn;
    } alu_op_t;
endpackage

// File: rtl/alu_cell.sv
module alu_cell
    import alu_pkg::*;
(
    input  logic    a_bit,
    input  logic    b_bit,
    input  logic    c_in,
    input  logic    inv_b,
    input  alu_fn_e fn,
    output logic    r_bit,
    output logic    c_out
);
    logic b_eff;
    logic half;

    always_comb begin
        b_eff = b_bit ^ inv_b;
        half  = a_bit ^ b_eff;
        c_out = (a_bit & b_eff) | (c_in & half);
        unique case (fn)
            FN_AND:  r_bit = a_bit & b_eff;
            FN_OR:   r_bit = a_bit | b_eff;
            FN_SUM:  r_bit = half ^ c_in;
            FN_XOR:  r_bit = half;
            default: r_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_zero_flag.sv
module alu_zero_flag #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] vec,
    output logic             all_zero
);
    assign all_zero = ~|vec;
endmodule

// File: rtl/alu_sliced.sv
module alu_sliced
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic [2:0]       op_in,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             zero_o
);
    localparam int unsigned CHAIN = WIDTH + 1;

    alu_op_t          op_s;
    logic [CHAIN-1:0] chain;
    logic [WIDTH-1:0] res_w;

    assign op_s     = alu_op_t'(op_in);
    assign chain[0] = op_s.inv_b;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_cell
        alu_cell u_cell (
            .a_bit (a_in[gi]),
            .b_bit (b_in[gi]),
            .c_in  (chain[gi]),
            .inv_b (op_s.inv_b),
            .fn    (op_s.fn),
            .r_bit (res_w[gi]),
            .c_out (chain[gi+1])
        );
    end

    assign result_o = res_w;
    assign carry_o  = (op_s.fn == FN_SUM) ? chain[WIDTH] : 1'b0;

    alu_zero_flag #(.WIDTH(WIDTH)) u_zero (
        .vec      (res_w),
        .all_zero (zero_o)
    );

    // Port-level checks against arithmetic, independent of the ripple chain
    always_comb begin
        if (op_in == 3'b010)
            p_sum_r2: assert ({carry_o, result_o} == ({1'b0, a_in} + {1'b0, b_in}));
        if (op_in == 3'b110)
            p_diff_r6: assert (result_o == a_in - b_in && carry_o == (a_in >= b_in));
        if (op_in == 3'b011)
            p_xor_r3: assert (result_o == (a_in ^ b_in));
        if (op_in == 3'b111)
            p_xnor_r5: assert (result_o == ~(a_in ^ b_in));
        if (op_in[1:0] != 2'b10)
            p_no_carry_r7: assert (carry_o == 1'b0);
        p_zero_r8: assert (zero_o == (result_o == '0));
    end
endmodule

// File: tb/tb_alu_sliced.sv
module tb_alu_sliced;
    logic        clk = 1'b0;
    logic [31:0] a_in, b_in;
    logic [2:0]  op_in;
    logic [31:0] result_o;
    logic        carry_o, zero_o;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    alu_sliced dut (
        .a_in(a_in), .b_in(b_in), .op_in(op_in),
        .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o)
    );

    function automatic string tag_of(logic [2:0] op);
        case (op)
            3'b000, 3'b001: return "R1";
            3'b010:         return "R2";
            3'b011:         return "R3";
            3'b100, 3'b101: return "R4";
            3'b110:         return "R6";
            default:        return "R5";
        endcase
    endfunction

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
        longint unsigned ua, ub, wide;
        logic [31:0] exp_r;
        logic        exp_c;
        ua = longint'(a);
        ub = longint'(b);
        exp_c = 1'b0;
        case (op)
            3'b000: exp_r = a & b;
            3'b001: exp_r = a | b;
            3'b010: begin wide = ua + ub; exp_r = wide[31:0]; exp_c = wide[32]; end
            3'b011: exp_r = a ^ b;
            3'b100: exp_r = a & ~b;
            3'b101: exp_r = a | ~b;
            3'b110: begin exp_r = a - b; exp_c = (ua >= ub); end
            default: exp_r = ~(a ^ b);
        endcase
        @(negedge clk);
        a_in = a; b_in = b; op_in = op;
        @(posedge clk);
        #1; // R9: results due in the same cycle, sampled away from the edge
        checks++;
        if (result_o !== exp_r) begin
            errors++;
            $display("FAIL %s R9 op=%b a=%h b=%h result actual=%h expected=%h",
                     tag_of(op), op, a, b, result_o, exp_r);
        end
        checks++;
        if (carry_o !== exp_c) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h carry actual=%b expected=%b",
                     (op[1:0] == 2'b10) ? tag_of(op) : "R7", op, a, b, carry_o, exp_c);
        end
        checks++;
        if (zero_o !== (exp_r == 32'h0)) begin
            errors++;
            $display("FAIL R8 op=%b a=%h b=%h zero actual=%b expected=%b",
                     op, a, b, zero_o, (exp_r == 32'h0));
        end
    endtask

    initial begin
        logic [31:0] corner [8];
        corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF;
        corner[2] = 32'h8000_0000; corner[3] = 32'h7FFF_FFFF;
        corner[4] = 32'h0000_0001; corner[5] = 32'hAAAA_5555;
        corner[6] = 32'h0000_0002; corner[7] = 32'h1234_5678;
        a_in = '0; b_in = '0; op_in = 3'b000;
        // Idle state: zero operands under AND give a zero result (R1, R8)
        apply(32'h0, 32'h0, 3'b000);
        for (int op = 0; op < 8; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    apply(corner[i], corner[j], 3'(op));
        // R6 borrow boundary and R2 wrap to zero
        apply(32'd5, 32'd5, 3'b110);
        apply(32'd4, 32'd5, 3'b110);
        apply(32'hFFFF_FFFF, 32'h1, 3'b010);
        // R5 XNOR of equal operands is all ones
        apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b111);
        for (int k = 0; k < 2000; k++)
            apply($urandom, $urandom, 3'($urandom_range(0, 7)));
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule